// File: doc/BRIEF.md
# Boot Strap Capture and Low-Window Remap Register

This block is a single memory-mapped system configuration word at address 0xF0000008. When the synchronous reset is released, it takes one sample of the board strap pins. Three pins give the boot mode and two give the default external data-bus width. After that, both fields are fixed until the next reset. The word also holds two software-writable flags. The remap flag moves the lowest 256 MB of the address space from boot ROM to RAM. The idle-direction flag selects whether the data bus is driven or floated between accesses.

The READY input reaches the register after a two-flop synchronizer, so software can poll it. A helper output gives the value to program into a chip-select configuration for a chosen bus width: the strapped width XOR the requested width. A region decoder looks at a memory address and raises a ROM or RAM select when the address falls in the low window.

Top module: `boot_strap_cfg`

## Requirements
- R1: While `rst` is high, and on the first read after a release with no write, the remap bit (bit 0) and the idle-direction bit (bit 14) read as 0. While `rst` is high the boot and width fields read as 0.
- R2: Bits [10:8] return `strap_boot` as sampled at the first rising clock edge at which `rst` is low after being high.
- R3: Bits [12:11] return `strap_width` as sampled at that same edge. The encodings are 00 or 01 for 32-bit, 10 for 16-bit and 11 for 8-bit.
- R4: After the capture edge, the boot and width fields keep their value whatever the strap pins do and whatever is written.
- R5: `cs_width` always equals the captured width field XOR `req_width`.
- R6: If `mem_addr[31:28]` is 0, `sel_rom` is high while the remap bit is 0 and `sel_ram` is high while it is 1. Any other address raises neither. A write to bit 0 changes the selects from the next clock cycle.
- R7: Bit 15 shows the level of `ready_pin` two rising edges after that level is applied. After one edge it does not yet show it.
- R8: Bit 14 is read/write and is driven on `bus_idle_drive`. 1 means the bus is driven when idle.
- R9: Writes have no effect on bits 15 and 12:8. Bits 31:16, 13 and 7:1 always read as 0.
- R10: A read at any other address returns 0, and a write to any other address does not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release triggers the strap capture |
| strap_boot | input | 3 | Boot-mode strap pins |
| strap_width | input | 2 | Bus-width strap pins |
| ready_pin | input | 1 | External READY pin, asynchronous |
| reg_addr | input | 32 | Register access address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| req_width | input | 2 | Desired bus width code for the XOR helper |
| cs_width | output | 2 | Code to program into a chip-select configuration |
| mem_addr | input | 32 | Memory address to decode |
| sel_rom | output | 1 | Low window maps to boot ROM |
| sel_ram | output | 1 | Low window maps to RAM |
| bus_idle_drive | output | 1 | Idle data-bus direction, 1 = driven |

## Verification
The capture is tested with strap values that change while reset is held and again after release. Reading back only the value present at the release edge shows that the capture is single-shot and not transparent. Two different resets use different strap patterns, so a stale capture is caught. Region decoding is probed inside the window, at the window's upper boundary, and before and after a remap write, which confirms the one-cycle update. The XOR helper is checked with three requested codes, and the READY path is sampled after one edge and after two edges to pin down the synchronizer depth.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned BOOT_W    = 3;
    localparam int unsigned BUS_W     = 2;
    localparam int unsigned REMAP_BIT = 0;
    localparam int unsigned BOOT_LSB  = 8;
    localparam int unsigned WIDTH_LSB = BOOT_LSB + BOOT_W;
    localparam int unsigned IDLE_BIT  = 14;
    localparam int unsigned READY_BIT = 15;
    localparam int unsigned WIN_BITS  = 4;

    typedef struct packed {
        logic [BUS_W-1:0]  width;
        logic [BOOT_W-1:0] boot;
    } strap_t;

    typedef enum logic [1:0] {
        REGION_NONE = 2'b00,
        REGION_ROM  = 2'b01,
        REGION_RAM  = 2'b10
    } region_e;

    typedef struct packed {
        logic   ready;
        logic   idle_drive;
        strap_t strap;
        logic   remap;
    } cfg_view_t;

    function automatic logic [WORD_W-1:0] pack_word(input cfg_view_t v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[READY_BIT]              = v.ready;
        w[IDLE_BIT]               = v.idle_drive;
        w[WIDTH_LSB +: BUS_W]     = v.strap.width;
        w[BOOT_LSB +: BOOT_W]     = v.strap.boot;
        w[REMAP_BIT]              = v.remap;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] used_mask();
        cfg_view_t v;
        v = '1;
        return pack_word(v);
    endfunction
endpackage

// File: rtl/bsc_strap_latch.sv
module bsc_strap_latch
    import bsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  strap_t strap_in,
    output strap_t strap_q
);
    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= '0;
        end else if (rst_d) begin
            strap_q <= strap_in;
        end
    end
endmodule

// File: rtl/bsc_ready_sync.sv
module bsc_ready_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              async_in,
    output logic [STAGES-1:0] chain_q
);
    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
        end
    end
endmodule

// File: rtl/bsc_region_dec.sv
module bsc_region_dec
    import bsc_pkg::*;
#(
    parameter int unsigned AW = WORD_W,
    parameter int unsigned WB = WIN_BITS
) (
    input  logic [AW-1:0] addr,
    input  logic          remap,
    output region_e       region
);
    logic in_window;

    always_comb begin
        in_window = (addr[AW-1 -: WB] == '0);
        if (!in_window)  region = REGION_NONE;
        else if (remap)  region = REGION_RAM;
        else             region = REGION_ROM;
    end
endmodule

// File: rtl/boot_strap_cfg.sv
module boot_strap_cfg
    import bsc_pkg::*;
#(
    parameter logic [31:0] CFG_ADDR    = 32'hF000_0008,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BOOT_W-1:0] strap_boot,
    input  logic [BUS_W-1:0]  strap_width,
    input  logic              ready_pin,
    input  logic [31:0]       reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [BUS_W-1:0]  req_width,
    output logic [BUS_W-1:0]  cs_width,
    input  logic [31:0]       mem_addr,
    output logic              sel_rom,
    output logic              sel_ram,
    output logic              bus_idle_drive
);
    strap_t                 strap_raw;
    strap_t                 strap_cap;
    logic [SYNC_STAGES-1:0] rdy_chain;
    logic                   rdy_bit;
    logic                   rdy_prev;
    logic                   remap_q;
    logic                   idle_q;
    logic                   hit;
    region_e                region;
    cfg_view_t              view;

    assign strap_raw.boot  = strap_boot;
    assign strap_raw.width = strap_width;

    bsc_strap_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .strap_in (strap_raw),
        .strap_q  (strap_cap)
    );

    bsc_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ready_pin),
        .chain_q  (rdy_chain)
    );

    assign rdy_bit  = rdy_chain[SYNC_STAGES-1];
    assign rdy_prev = rdy_chain[SYNC_STAGES-2];

    assign hit = (reg_addr == CFG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            remap_q <= 1'b0;
            idle_q  <= 1'b0;
        end else if (reg_wr && hit) begin
            remap_q <= reg_wdata[REMAP_BIT];
            idle_q  <= reg_wdata[IDLE_BIT];
        end
    end

    always_comb begin
        view.ready      = rdy_bit;
        view.idle_drive = idle_q;
        view.strap      = strap_cap;
        view.remap      = remap_q;
        reg_rdata       = hit ? pack_word(view) : '0;
    end

    bsc_region_dec u_dec (
        .addr   (mem_addr),
        .remap  (remap_q),
        .region (region)
    );

    assign sel_rom        = (region == REGION_ROM);
    assign sel_ram        = (region == REGION_RAM);
    assign cs_width       = strap_cap.width ^ req_width;
    assign bus_idle_drive = idle_q;
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker
    import bsc_pkg::*;
#(
    parameter logic [31:0] CFG_ADDR = 32'hF000_0008
) (
    input logic              clk,
    input logic              rst,
    input logic [BOOT_W-1:0] strap_boot,
    input logic [BUS_W-1:0]  strap_width,
    input logic [BOOT_W-1:0] cap_boot,
    input logic [BUS_W-1:0]  cap_width,
    input logic              rdy_prev,
    input logic              rdy_bit,
    input logic              remap_q,
    input logic [31:0]       reg_addr,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [31:0]       mem_addr,
    input logic              sel_rom,
    input logic              sel_ram
);
    // R2 R3
    strap_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> (cap_boot == $past(strap_boot)) && (cap_width == $past(strap_width)));

    // R4
    strap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> ($stable(cap_boot) && $stable(cap_width)));

    // R7
    ready_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rdy_bit == $past(rdy_prev)));

    // R6
    region_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_rom, sel_ram}));

    // R6
    remap_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == CFG_ADDR) |=> (remap_q == $past(reg_wdata[REMAP_BIT])));

    // R6
    outside_window_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_addr[31:28] != 4'h0) |-> (!sel_rom && !sel_ram));

    // R9
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((reg_rdata & ~used_mask()) == '0));
endmodule

bind boot_strap_cfg bsc_checker #(.CFG_ADDR(CFG_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .strap_boot  (strap_boot),
    .strap_width (strap_width),
    .cap_boot    (strap_cap.boot),
    .cap_width   (strap_cap.width),
    .rdy_prev    (rdy_prev),
    .rdy_bit     (rdy_bit),
    .remap_q     (remap_q),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .mem_addr    (mem_addr),
    .sel_rom     (sel_rom),
    .sel_ram     (sel_ram)
);

// File: tb/tb_boot_strap_cfg.sv
`timescale 1ns/100ps
module tb_boot_strap_cfg;
    localparam logic [31:0] REG_A   = 32'hF000_0008;
    localparam logic [31:0] OTHER_A = 32'hF000_000C;

    typedef enum int { OBS_RDATA, OBS_CSW, OBS_SEL, OBS_IDLE } obs_e;
    typedef struct {
        obs_e        kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 0;
    logic        rst = 1;
    logic [2:0]  strap_boot = 3'b101;
    logic [1:0]  strap_width = 2'b10;
    logic        ready_pin = 0;
    logic [31:0] reg_addr = REG_A;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [1:0]  req_width = 0;
    logic [1:0]  cs_width;
    logic [31:0] mem_addr = 0;
    logic        sel_rom, sel_ram, bus_idle_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    item_t q[$];

    always #2.5 clk = ~clk;

    boot_strap_cfg dut (
        .clk(clk), .rst(rst), .strap_boot(strap_boot), .strap_width(strap_width),
        .ready_pin(ready_pin), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_width(req_width),
        .cs_width(cs_width), .mem_addr(mem_addr), .sel_rom(sel_rom),
        .sel_ram(sel_ram), .bus_idle_drive(bus_idle_drive)
    );

    // monitor: pops expectations one time unit after each rising edge
    always @(posedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                OBS_RDATA: act = reg_rdata;
                OBS_CSW:   act = {30'd0, cs_width};
                OBS_SEL:   act = {30'd0, sel_ram, sel_rom};
                default:   act = {31'd0, bus_idle_drive};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_at(input obs_e k, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_wr = 0; reg_addr = a;
        expect_at(OBS_RDATA, e, tag);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_addr = REG_A;
    endtask

    task automatic sel_chk(input logic [31:0] ma, input logic [1:0] e, input string tag);
        @(negedge clk);
        reg_wr = 0; mem_addr = ma;
        expect_at(OBS_SEL, {30'd0, e}, tag);
    endtask

    task automatic csw_chk(input logic [1:0] rq, input logic [1:0] e, input string tag);
        @(negedge clk);
        req_width = rq;
        expect_at(OBS_CSW, {30'd0, e}, tag);
    endtask

    initial begin
        repeat (3) idle_cycle();
        rd(REG_A, 32'h0, "R1 reset read");
        // straps move while reset is held; only the release value counts
        @(negedge clk);
        strap_boot = 3'b110; strap_width = 2'b11;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        strap_boot = 3'b001; strap_width = 2'b01;
        rd(REG_A, 32'h0000_1E00, "R2 R3 capture boot=110 width=11");
        rd(REG_A, 32'h0000_1E00, "R1 flags zero after release");
        expect_at(OBS_IDLE, 32'h0, "R1 idle drive low after release");
        repeat (3) idle_cycle();
        rd(REG_A, 32'h0000_1E00, "R4 straps frozen");
        // XOR helper: strapped 11
        csw_chk(2'b00, 2'b11, "R5 req 32-bit");
        csw_chk(2'b10, 2'b01, "R5 req 16-bit");
        csw_chk(2'b11, 2'b00, "R5 req 8-bit");
        // region before remap
        sel_chk(32'h0000_1000, 2'b01, "R6 low window rom");
        sel_chk(32'h0FFF_FFFF, 2'b01, "R6 window top rom");
        sel_chk(32'h1000_0000, 2'b00, "R6 above window");
        @(negedge clk);
        mem_addr = 32'h0000_1000;
        reg_wr = 1; reg_addr = REG_A; reg_wdata = 32'hFFFF_FFFF;
        expect_at(OBS_SEL, 32'h2, "R6 ram on cycle after write");
        @(negedge clk);
        reg_wr = 0;
        rd(REG_A, 32'h0000_5E01, "R9 R8 only rw bits change");
        expect_at(OBS_IDLE, 32'h1, "R8 idle drive high");
        sel_chk(32'h1000_0000, 2'b00, "R6 above window after remap");
        // READY synchronizer
        @(negedge clk);
        ready_pin = 1; reg_addr = REG_A;
        expect_at(OBS_RDATA, 32'h0000_5E01, "R7 not visible after one edge");
        rd(REG_A, 32'h0000_DE01, "R7 visible after two edges");
        // other address
        wr(OTHER_A, 32'h0);
        rd(REG_A, 32'h0000_DE01, "R10 write elsewhere ignored");
        rd(OTHER_A, 32'h0, "R10 read elsewhere zero");
        wr(REG_A, 32'h0);
        rd(REG_A, 32'h0000_9E00, "R8 clear flags");
        expect_at(OBS_IDLE, 32'h0, "R8 idle drive low");
        sel_chk(32'h0000_0000, 2'b01, "R6 back to rom");
        // second reset with new straps
        @(negedge clk);
        rst = 1; strap_boot = 3'b011; strap_width = 2'b00;
        rd(REG_A, 32'h0, "R1 read during second reset");
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        strap_boot = 3'b111; strap_width = 2'b10;
        repeat (2) idle_cycle();
        rd(REG_A, 32'h0000_8300, "R2 R3 second capture");
        csw_chk(2'b10, 2'b10, "R5 strapped 00 req 16-bit");
        repeat (2) idle_cycle();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule